// File: doc/BRIEF.md
# Word-Packed Transfer FIFO Pair

This block sits between a host register bus and the byte engine of a packet-mode I2C master. The host side moves 32-bit words and the engine side moves single bytes. Outgoing words are split into bytes, lowest byte first. Incoming bytes are packed into words in the same order. A message whose length is not a multiple of four still ends on a whole word. The engine marks the last byte of such a message. For outgoing data, that mark drops the rest of the current word. For incoming data, it closes the word early, and the unused upper bytes read as zero.

A control register sets two trigger levels and holds two flush bits. Each flush bit clears itself once its flush is done. A status register reports how many transmit slots are free and how many receive words are waiting. For each direction, the block drives a data-request line to the interrupt logic, based on the level compared with the trigger. A write to a full transmit FIFO and a read of an empty receive FIFO each produce a one-cycle error pulse.

Top module: `wpf_xfer_fifos`

## Requirements
- R1: After reset, status reads 0x80 (8 free, 0 filled), control reads 0, `eng_tx_valid` is low, `eng_rx_ready` is high, `tx_req` is high and `rx_req` is low.
- R2: A word written to address 2 is offered to the engine as bytes in the order bits [7:0], [15:8], [23:16], [31:24]. Each byte advances when `eng_tx_take` is high and `eng_tx_valid` is high.
- R3: A host write to address 2 while all 8 transmit slots are used is discarded, and `tx_overflow` is high for exactly the one cycle after that write.
- R4: A take with `eng_tx_last` high retires the current transmit word. The next byte offered is byte 0 of the following word.
- R5: Four bytes pushed with `eng_rx_put` form one receive word, with the first byte in bits [7:0]. The filled count rises when the fourth byte is accepted. Reading address 3 returns the oldest word and removes it.
- R6: A byte pushed with `eng_rx_last` high closes the receive word early. Its unfilled upper bytes read as zero.
- R7: A read of address 3 while the receive FIFO is empty returns 0 and leaves both counts unchanged. `rx_underflow` is high for the one cycle after that read.
- R8: Writing 1 to control bit 1 flushes the transmit FIFO, and writing 1 to bit 0 flushes the receive FIFO. A bit reads back as 1 in the cycle after the write and as 0 once the flush is done, one cycle later. The flush resets that FIFO to empty, discards any part-assembled word, and leaves the other direction alone.
- R9: The transmit trigger level is held in control bits [7:5] and the receive trigger level in bits [4:2]. Both read back as written.
- R10: `tx_req` is high while the free transmit slots exceed the transmit trigger. `rx_req` is high while the filled receive words exceed the receive trigger.
- R11: Status (address 1) bits [7:4] give the free transmit word slots and bits [3:0] give the filled receive words. Free slots return to 8 after a transmit flush.
- R12: If a host pop and an engine-side word completion fall in the same cycle, the FIFO applies both. The count is unchanged and no data is lost: a receive read returns the old head while a new word lands, and a transmit write is accepted while the engine retires a word.
- R13: `eng_tx_valid` is low while the transmit FIFO is empty. `eng_rx_ready` is low while the receive FIFO holds 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops at address 3) |
| host_addr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the read |
| eng_tx_valid | output | 1 | A transmit byte is on offer |
| eng_tx_byte | output | 8 | Transmit byte on offer |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_tx_last | input | 1 | With a take: retire the rest of the current word |
| eng_rx_ready | output | 1 | Receive FIFO has a free word slot |
| eng_rx_put | input | 1 | Engine delivers a receive byte |
| eng_rx_byte | input | 8 | Receive byte |
| eng_rx_last | input | 1 | With a put: close the word early |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_overflow | output | 1 | One-cycle pulse on a write to a full transmit FIFO |
| rx_underflow | output | 1 | One-cycle pulse on a read of an empty receive FIFO |

## Verification
Two kinds of event can land in the same clock edge: a host-side access and an engine-side word boundary on the same FIFO. On the receive side, the bench drives a read of address 3 in the same cycle as the byte that completes the next word. The read must return the older word, and the filled count must stay at one. A second read must then return the new word. On the transmit side, the bench writes a word in the cycle the engine takes the last byte of the head word. The free count must not change, and the next byte offered must be byte 0 of the newly written word.

// File: rtl/wpf_pkg.sv
// Package: shared constants of the word-packed transfer FIFO pair.
// Assumes a 2-bit host address space and an 8-bit control/status layout.
package wpf_pkg;
    localparam int WORD_BYTES     = 4;
    localparam int WORD_W         = WORD_BYTES * 8;
    localparam int TRIG_W         = 3;
    localparam int CTL_RXF_BIT    = 0;
    localparam int CTL_TXF_BIT    = 1;
    localparam int CTL_RXTRIG_LSB = 2;
    localparam int CTL_TXTRIG_LSB = CTL_RXTRIG_LSB + TRIG_W;
    localparam int STAT_FIELD_W   = 4;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wpf_word_fifo.sv
// Module: synchronous word FIFO with a clear input.
// Assumes: push to a full FIFO and pop of an empty one are ignored;
// clr wins over push and pop in the same cycle.
module wpf_word_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R11
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R8
    AST_PUSH_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !clr) |=> $stable(count)); // R12
endmodule

// File: rtl/wpf_tx_unpack.sv
// Module: transmit FIFO plus word-to-byte unpacker.
// Assumes the engine asserts take only to consume the offered byte;
// a take with last retires the remainder of the head word.
module wpf_tx_unpack #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       host_push,
    input  logic [wpf_pkg::WORD_W-1:0] host_word,
    input  logic                       eng_take,
    input  logic                       eng_last,
    output logic                       eng_valid,
    output logic [7:0]                 eng_byte,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int BI_W = $clog2(wpf_pkg::WORD_BYTES);
    localparam logic [BI_W-1:0] TOP_BYTE = BI_W'(wpf_pkg::WORD_BYTES - 1);

    logic [wpf_pkg::WORD_W-1:0] head;
    logic                       empty;
    logic [BI_W-1:0]            idx;
    logic                       accept, word_done;

    assign eng_valid = !empty;
    assign eng_byte  = head[{idx, 3'b000} +: 8];
    assign accept    = eng_take && eng_valid && !clr;
    assign word_done = accept && (eng_last || idx == TOP_BYTE);

    wpf_word_fifo #(.DEPTH(DEPTH), .WIDTH(wpf_pkg::WORD_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (host_push),
        .push_data (host_word),
        .pop       (word_done),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    // Byte index within the head word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (accept) begin
            idx <= word_done ? '0 : idx + 1'b1;
        end
    end

    AST_TX_VALID_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> (count != '0)); // R13
    AST_TX_LAST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_take && eng_valid && eng_last && !clr) |=> (idx == '0)); // R4
endmodule

// File: rtl/wpf_rx_pack.sv
// Module: byte-to-word packer plus receive FIFO.
// Assumes the engine honours eng_ready; a word completed while the FIFO
// is full is lost. A flush discards the part-assembled word.
module wpf_rx_pack #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       eng_put,
    input  logic [7:0]                 eng_byte,
    input  logic                       eng_last,
    output logic                       eng_ready,
    input  logic                       host_pop,
    output logic [wpf_pkg::WORD_W-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);
    localparam int BI_W = $clog2(wpf_pkg::WORD_BYTES);
    localparam logic [BI_W-1:0] TOP_BYTE = BI_W'(wpf_pkg::WORD_BYTES - 1);

    logic [wpf_pkg::WORD_W-1:0] accum, merged;
    logic [BI_W-1:0]            bidx;
    logic                       full, take_byte, word_close;

    assign eng_ready  = !full;
    assign take_byte  = eng_put && !clr;
    assign word_close = take_byte && (eng_last || bidx == TOP_BYTE);

    // Merge the incoming byte into the lane chosen by the byte index.
    always_comb begin
        merged = accum;
        merged[{bidx, 3'b000} +: 8] = eng_byte;
    end

    wpf_word_fifo #(.DEPTH(DEPTH), .WIDTH(wpf_pkg::WORD_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (word_close),
        .push_data (merged),
        .pop       (host_pop),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    // Partial word accumulator and its byte index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || word_close) begin
            accum <= '0;
            bidx  <= '0;
        end else if (take_byte) begin
            accum <= merged;
            bidx  <= bidx + 1'b1;
        end
    end

    AST_RX_READY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ready |-> (count < ($clog2(DEPTH+1))'(DEPTH))); // R13
endmodule

// File: rtl/wpf_ctrl.sv
// Module: control register with self-clearing flush requests and trigger levels.
// Assumes a flush requested by a write executes in the following cycle.
module wpf_ctrl (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_ctl,
    input  logic [7:0]                 wdata,
    output logic                       tx_flush,
    output logic                       rx_flush,
    output logic [wpf_pkg::TRIG_W-1:0] tx_trig,
    output logic [wpf_pkg::TRIG_W-1:0] rx_trig,
    output logic [7:0]                 ctl_rdata
);
    import wpf_pkg::*;

    // Trigger levels hold until rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_trig <= '0;
            rx_trig <= '0;
        end else if (wr_ctl) begin
            tx_trig <= wdata[CTL_TXTRIG_LSB +: TRIG_W];
            rx_trig <= wdata[CTL_RXTRIG_LSB +: TRIG_W];
        end
    end

    // Flush requests live for exactly one cycle unless rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= wr_ctl && wdata[CTL_TXF_BIT];
            rx_flush <= wr_ctl && wdata[CTL_RXF_BIT];
        end
    end

    // Readback image of the control register.
    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[CTL_TXF_BIT] = tx_flush;
        ctl_rdata[CTL_RXF_BIT] = rx_flush;
        ctl_rdata[CTL_TXTRIG_LSB +: TRIG_W] = tx_trig;
        ctl_rdata[CTL_RXTRIG_LSB +: TRIG_W] = rx_trig;
    end

    AST_TX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !(wr_ctl && wdata[CTL_TXF_BIT])) |=> !tx_flush); // R8
    AST_RX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush && !(wr_ctl && wdata[CTL_RXF_BIT])) |=> !rx_flush); // R8
endmodule

// File: rtl/wpf_xfer_fifos.sv
// Module: top of the word-packed transfer FIFO pair.
// Decodes the host register bus, builds the status word, drives the
// data-request lines and the overflow/underflow pulses.
// Assumes DEPTH <= 15 so both counts fit their 4-bit status fields.
module wpf_xfer_fifos #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_tx_take,
    input  logic        eng_tx_last,
    output logic        eng_rx_ready,
    input  logic        eng_rx_put,
    input  logic [7:0]  eng_rx_byte,
    input  logic        eng_rx_last,
    output logic        tx_req,
    output logic        rx_req,
    output logic        tx_overflow,
    output logic        rx_underflow
);
    import wpf_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     tx_count, rx_count, tx_free;
    logic              tx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic              tx_flush, rx_flush;
    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic [7:0]        ctl_rdata, stat_rdata;
    logic              wr_ctl, wr_txd, rd_rxd;

    assign wr_ctl  = host_wr && (host_addr == REG_CTL);
    assign wr_txd  = host_wr && (host_addr == REG_TXD);
    assign rd_rxd  = host_rd && (host_addr == REG_RXD);
    assign tx_free = CW'(DEPTH) - tx_count;

    wpf_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wdata     (host_wdata[7:0]),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush),
        .tx_trig   (tx_trig),
        .rx_trig   (rx_trig),
        .ctl_rdata (ctl_rdata)
    );

    wpf_tx_unpack #(.DEPTH(DEPTH)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_flush),
        .host_push (wr_txd),
        .host_word (host_wdata),
        .eng_take  (eng_tx_take),
        .eng_last  (eng_tx_last),
        .eng_valid (eng_tx_valid),
        .eng_byte  (eng_tx_byte),
        .count     (tx_count),
        .full      (tx_full)
    );

    wpf_rx_pack #(.DEPTH(DEPTH)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_flush),
        .eng_put   (eng_rx_put),
        .eng_byte  (eng_rx_byte),
        .eng_last  (eng_rx_last),
        .eng_ready (eng_rx_ready),
        .host_pop  (rd_rxd),
        .head      (rx_head),
        .count     (rx_count),
        .empty     (rx_empty)
    );

    // Status word: free transmit slots high nibble, filled receive words low.
    assign stat_rdata = {STAT_FIELD_W'(tx_free), STAT_FIELD_W'(rx_count)};

    // Host read data selection.
    always_comb begin
        unique case (host_addr)
            REG_CTL:  host_rdata = {24'd0, ctl_rdata};
            REG_STAT: host_rdata = {24'd0, stat_rdata};
            REG_RXD:  host_rdata = rx_empty ? '0 : rx_head;
            default:  host_rdata = '0;
        endcase
    end

    // Level-driven data requests.
    assign tx_req = tx_free  > CW'(tx_trig);
    assign rx_req = rx_count > CW'(rx_trig);

    // One-cycle error pulses for bad host accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            tx_overflow  <= wr_txd && tx_full;
            rx_underflow <= (host_rd && host_addr == REG_RXD) && rx_empty;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |-> ($past(tx_count) == CW'(DEPTH))); // R3
    AST_OVERFLOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full && !eng_tx_take && !tx_flush) |=> $stable(tx_count)); // R3
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_count == '0) |-> (host_rdata == '0)); // R7
    AST_UNDERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_underflow |=> !rx_underflow || $past(rd_rxd)); // R7
endmodule

// File: tb/test_wpf_xfer_fifos.sv
module test_wpf_xfer_fifos;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_take = 1'b0, eng_tx_last = 1'b0;
    logic        eng_rx_ready;
    logic        eng_rx_put = 1'b0, eng_rx_last = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        tx_req, rx_req, tx_overflow, rx_underflow;

    int total = 0;
    int bad = 0;

    localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

    always #5 clk = ~clk;

    wpf_xfer_fifos i_wpf_xfer_fifos (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_tx_take(eng_tx_take), .eng_tx_last(eng_tx_last),
        .eng_rx_ready(eng_rx_ready), .eng_rx_put(eng_rx_put),
        .eng_rx_byte(eng_rx_byte), .eng_rx_last(eng_rx_last),
        .tx_req(tx_req), .rx_req(rx_req),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic take_byte(input logic last, output logic [7:0] b, output logic v);
        @(negedge clk);
        v = eng_tx_valid; b = eng_tx_byte;
        eng_tx_take = 1'b1; eng_tx_last = last;
        @(posedge clk); #1;
        eng_tx_take = 1'b0; eng_tx_last = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        eng_rx_put = 1'b1; eng_rx_byte = b; eng_rx_last = last;
        @(posedge clk); #1;
        eng_rx_put = 1'b0; eng_rx_last = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) put_byte(w[k*8 +: 8], 1'b0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        host_read(A_STAT, d); chk("R1 status", d, 32'h80);
        host_read(A_CTL, d);  chk("R1 control", d, 32'h0);
        chk("R1 tx_valid", eng_tx_valid, 0);
        chk("R1 rx_ready", eng_rx_ready, 1);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 rx_req", rx_req, 0);
    endtask

    task automatic t_tx_order;
        logic [7:0] b; logic v;
        host_write(A_TXD, 32'h44332211);
        take_byte(0, b, v); chk("R2 byte0", {v, b}, {1'b1, 8'h11});
        take_byte(0, b, v); chk("R2 byte1", b, 8'h22);
        take_byte(0, b, v); chk("R2 byte2", b, 8'h33);
        take_byte(0, b, v); chk("R2 byte3", b, 8'h44);
        chk("R13 tx_valid empty", eng_tx_valid, 0);
    endtask

    task automatic t_tx_partial;
        logic [7:0] b; logic v;
        host_write(A_TXD, 32'hAABBCCDD);
        host_write(A_TXD, 32'h00000066);
        take_byte(0, b, v); chk("R4 first", b, 8'hDD);
        take_byte(1, b, v); chk("R4 last byte", b, 8'hCC);
        take_byte(1, b, v); chk("R4 next word byte0", b, 8'h66);
        chk("R4 drained", eng_tx_valid, 0);
    endtask

    task automatic t_overflow;
        logic [31:0] d; logic [7:0] b; logic v;
        for (int i = 0; i < 8; i++) host_write(A_TXD, 32'hA0A0A0A0 + i);
        host_read(A_STAT, d); chk("R11 tx full status", d, 32'h00);
        chk("R10 tx_req full", tx_req, 0);
        host_write(A_TXD, 32'hDEADBEEF);
        chk("R3 overflow pulse", tx_overflow, 1);
        idle(1);
        chk("R3 overflow one cycle", tx_overflow, 0);
        host_read(A_STAT, d); chk("R3 count kept", d, 32'h00);
        take_byte(0, b, v); chk("R3 head intact", b, 8'hA0);
        host_write(A_CTL, 32'h02);
        idle(1);
        host_read(A_STAT, d); chk("R11 free after flush", d, 32'h80);
    endtask

    task automatic t_rx_pack;
        logic [31:0] d;
        put_byte(8'hA1, 0); put_byte(8'hB2, 0); put_byte(8'hC3, 0);
        host_read(A_STAT, d); chk("R5 not yet a word", d, 32'h80);
        put_byte(8'hD4, 0);
        host_read(A_STAT, d); chk("R5 one word", d, 32'h81);
        host_read(A_RXD, d);  chk("R5 word value", d, 32'hD4C3B2A1);
        host_read(A_STAT, d); chk("R5 popped", d, 32'h80);
    endtask

    task automatic t_rx_partial;
        logic [31:0] d;
        put_byte(8'h5A, 0); put_byte(8'h6B, 1);
        host_read(A_RXD, d); chk("R6 partial word", d, 32'h00006B5A);
    endtask

    task automatic t_underflow;
        logic [31:0] d;
        host_read(A_RXD, d); chk("R7 empty read zero", d, 32'h0);
        chk("R7 underflow pulse", rx_underflow, 1);
        idle(1);
        chk("R7 pulse one cycle", rx_underflow, 0);
        host_read(A_STAT, d); chk("R7 counts unchanged", d, 32'h80);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        put_word(32'h01010101); put_word(32'h02020202);
        put_byte(8'h77, 0);
        host_write(A_TXD, 32'h0000CAFE);
        host_write(A_CTL, 32'h01);
        host_read(A_CTL, d);  chk("R8 flush bit reads 1", d, 32'h01);
        host_read(A_CTL, d);  chk("R8 flush bit self-clears", d, 32'h00);
        host_read(A_STAT, d); chk("R8 rx emptied tx kept", d, 32'h70);
        put_byte(8'h11, 1);
        host_read(A_RXD, d);  chk("R8 partial discarded", d, 32'h00000011);
        host_write(A_CTL, 32'h02);
        host_read(A_CTL, d);  chk("R8 tx flush bit reads 1", d, 32'h02);
        host_read(A_STAT, d); chk("R8 tx emptied", d, 32'h80);
    endtask

    task automatic t_trig;
        logic [31:0] d;
        host_write(A_CTL, 32'hA8);
        host_read(A_CTL, d); chk("R9 trigger readback", d, 32'hA8);
        chk("R10 tx_req free 8 > 5", tx_req, 1);
        for (int i = 0; i < 3; i++) host_write(A_TXD, i);
        chk("R10 tx_req free 5", tx_req, 0);
        put_word(32'h1); put_word(32'h2);
        chk("R10 rx_req filled 2", rx_req, 0);
        put_word(32'h3);
        chk("R10 rx_req filled 3", rx_req, 1);
        host_write(A_CTL, 32'h03);
        idle(1);
        host_read(A_STAT, d); chk("R8 both flushed", d, 32'h80);
    endtask

    task automatic t_collide;
        logic [31:0] d; logic [7:0] b; logic v;
        put_word(32'h04030201);
        put_byte(8'h05, 0); put_byte(8'h06, 0); put_byte(8'h07, 0);
        @(negedge clk);
        host_rd = 1'b1; host_addr = A_RXD;
        eng_rx_put = 1'b1; eng_rx_byte = 8'h08; eng_rx_last = 1'b0;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0; eng_rx_put = 1'b0;
        chk("R12 rx old head", d, 32'h04030201);
        host_read(A_STAT, d); chk("R12 rx count kept", d, 32'h81);
        host_read(A_RXD, d);  chk("R12 rx new word", d, 32'h08070605);
        host_write(A_TXD, 32'h000000EE);
        take_byte(0, b, v); take_byte(0, b, v); take_byte(0, b, v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = A_TXD; host_wdata = 32'h12345678;
        eng_tx_take = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; eng_tx_take = 1'b0;
        host_read(A_STAT, d); chk("R12 tx free kept", d, 32'h70);
        take_byte(0, b, v); chk("R12 tx new head", b, 8'h78);
        host_write(A_CTL, 32'h02);
        idle(1);
    endtask

    task automatic t_rx_full;
        logic [31:0] d;
        for (int i = 0; i < 8; i++) put_word(32'h100 + i);
        chk("R13 rx_ready low when full", eng_rx_ready, 0);
        host_read(A_STAT, d); chk("R11 rx full status", d, 32'h88);
        host_read(A_RXD, d);  chk("R5 fifo order", d, 32'h100);
        chk("R13 rx_ready back", eng_rx_ready, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_tx_order();
        t_tx_partial();
        t_overflow();
        t_rx_pack();
        t_rx_partial();
        t_underflow();
        t_flush();
        t_trig();
        t_collide();
        t_rx_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule